// File: doc/BRIEF.md
# DRAM Chip-Select Row Decoder

This block maps a 4 KiB page number to the DRAM row that holds it. Eight rows each carry a programmed 8-bit cumulative boundary: the boundary of a row gives the total memory from row 0 up to and including that row. The block turns each boundary into a page limit. Row i then covers the pages from the boundary of row i-1 (row 0 starts at page 0) up to one page below its own boundary.

For the row found, the block also reports the DRAM device width of that row and the error-correction scheme that applies there. The scheme depends on the integrity-mode field, the channel count and the width of the row. A query is presented with a valid strobe. The answer is registered and appears on the next clock edge with its own valid flag. The boundary, attribute and mode words are plain inputs that the surrounding logic holds steady.

Top module: `dram_row_locator`

## Requirements
- R1: While reset is asserted and after it is released, before any query, r_valid_o, r_hit_o, r_row_o, r_x4_o and r_ecc_o are all zero.
- R2: r_valid_o is high exactly in the cycle after a cycle with q_valid_i high. The result outputs change only on such a cycle and otherwise hold their last value.
- R3: Row i covers pages lo_i <= page < hi_i. Here hi_i is boundary i times the unit, lo_i is boundary i-1 times the unit, and lo_0 = 0. Boundary i sits at bits 8*i+7:8*i of bnd_i. A page inside a populated row gives r_hit_o=1 and r_row_o=i.
- R4: Bit 18 of mode_i selects the boundary unit. 0 gives 8192 pages (32 MiB) and 1 gives 16384 pages (64 MiB).
- R5: A row whose boundary equals the previous boundary (for row 0, equals zero) is unpopulated and is never reported as a hit.
- R6: A page that falls in no populated row gives r_hit_o=0, r_row_o=0, r_x4_o=0 and r_ecc_o=0. This includes any page at or above the last boundary and the case where all boundaries are zero.
- R7: When the ranges of several populated rows contain the page, the lowest row index is reported.
- R8: On a hit, r_x4_o equals bit 4*r_row_o+3 of attr_i (1 = x4 devices, 0 = x8).
- R9: On a hit, r_ecc_o is 0 (none) if mode_i[21:20] is 0. Otherwise it is 2 (4-bit symbol code) when mode_i[22] is 1 (two channels) and the row is x4, and 1 (SECDED) in all other cases. The code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_i | input | 64 | Eight cumulative boundaries, row i at bits 8*i+7:8*i |
| attr_i | input | 32 | Row attribute word, width flag of row i at bit 4*i+3 |
| mode_i | input | 32 | Controller mode: bit 18 unit, bits 21:20 integrity mode, bit 22 dual channel |
| q_valid_i | input | 1 | Query strobe |
| q_page_i | input | 24 | Queried page number (4 KiB pages) |
| r_valid_o | output | 1 | Result valid, one cycle after the strobe |
| r_hit_o | output | 1 | Page lies in a populated row |
| r_row_o | output | 3 | Index of the row found |
| r_x4_o | output | 1 | Device width of that row (1 = x4) |
| r_ecc_o | output | 2 | ECC scheme: 0 none, 1 SECDED, 2 4-bit symbol code |

## Verification
A wrong page limit or populated flag shows at the ports as a wrong row index or a missing hit. It appears on the first query that lands between the true limit and the faulty one, one cycle after the strobe. This is why the directed queries sit on the last page of each row and the first page of the next, in both unit sizes and with empty rows in between. A faulty priority choice shows only where ranges overlap, so overlapping boundaries are programmed on purpose. A wrong width or ECC selection shows in the same result cycle as a wrong r_x4_o or r_ecc_o for a row whose attribute bit is set.

// File: rtl/rowloc_pkg.sv
package rowloc_pkg;

  // Field positions in the controller mode word
  localparam int MODE_W    = 32;
  localparam int GRAN_BIT  = 18;
  localparam int INTEG_LSB = 20;
  localparam int CHAN_BIT  = 22;

  typedef enum logic [1:0] {
    ECC_OFF    = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYM4   = 2'd2
  } ecc_code_t;

  // Scheme chosen for one row from the integrity mode, channel count and width
  function automatic ecc_code_t ecc_pick(input logic [1:0] integ,
                                         input logic dual,
                                         input logic x4);
    if (integ == 2'd0)   return ECC_OFF;
    else if (dual && x4) return ECC_SYM4;
    else                 return ECC_SECDED;
  endfunction

endpackage

// File: rtl/rowloc_bounds.sv
module rowloc_bounds #(
  parameter int N_ROWS     = 8,
  parameter int BND_W      = 8,
  parameter int PAGE_W     = 24,
  parameter int UNIT_SHIFT = 13
) (
  input  logic [N_ROWS*BND_W-1:0]  bnd_i,
  input  logic                     gran_i,
  output logic [N_ROWS*PAGE_W-1:0] lo_o,
  output logic [N_ROWS*PAGE_W-1:0] hi_o,
  output logic [N_ROWS-1:0]        pop_o
);

  // Boundary value in units -> page limit
  function automatic logic [PAGE_W-1:0] to_pages(input logic [BND_W-1:0] b,
                                                 input logic g);
    logic [PAGE_W-1:0] w;
    w = '0;
    w[BND_W-1:0] = b;
    return w << (UNIT_SHIFT + (g ? 1 : 0));
  endfunction

  for (genvar i = 0; i < N_ROWS; i++) begin : g_row
    logic [BND_W-1:0] cur_b;
    logic [BND_W-1:0] prev_b;
    assign cur_b = bnd_i[i*BND_W +: BND_W];
    if (i == 0) begin : g_first
      assign prev_b = '0;
    end else begin : g_rest
      assign prev_b = bnd_i[(i-1)*BND_W +: BND_W];
    end
    assign pop_o[i]                = (cur_b != prev_b);
    assign lo_o[i*PAGE_W +: PAGE_W] = to_pages(prev_b, gran_i);
    assign hi_o[i*PAGE_W +: PAGE_W] = to_pages(cur_b, gran_i);
  end

endmodule

// File: rtl/rowloc_match.sv
module rowloc_match #(
  parameter int N_ROWS = 8,
  parameter int PAGE_W = 24,
  localparam int IDX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic [PAGE_W-1:0]        page_i,
  input  logic [N_ROWS*PAGE_W-1:0] lo_i,
  input  logic [N_ROWS*PAGE_W-1:0] hi_i,
  input  logic [N_ROWS-1:0]        pop_i,
  output logic [N_ROWS-1:0]        first_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);

  logic [N_ROWS-1:0] cand;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_cmp
    assign cand[i] = pop_i[i]
                   && (page_i >= lo_i[i*PAGE_W +: PAGE_W])
                   && (page_i <  hi_i[i*PAGE_W +: PAGE_W]);
  end

  // Lowest-index candidate wins
  always_comb begin
    logic taken;
    taken   = 1'b0;
    first_o = '0;
    idx_o   = '0;
    for (int i = 0; i < N_ROWS; i++) begin
      if (cand[i] && !taken) begin
        taken      = 1'b1;
        first_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
    hit_o = taken;
  end

endmodule

// File: rtl/rowloc_attr.sv
module rowloc_attr
  import rowloc_pkg::*;
#(
  parameter int N_ROWS = 8,
  localparam int IDX_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int ATTR_W = 4 * N_ROWS
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              dual_i,
  input  logic [1:0]        integ_i,
  output logic              x4_o,
  output ecc_code_t         ecc_o
);

  logic [N_ROWS-1:0] wvec;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_w
    assign wvec[i] = attr_i[4*i+3];
  end

  always_comb begin
    x4_o  = 1'b0;
    ecc_o = ECC_OFF;
    if (hit_i) begin
      x4_o  = wvec[idx_i];
      ecc_o = ecc_pick(integ_i, dual_i, wvec[idx_i]);
    end
  end

endmodule

// File: rtl/dram_row_locator.sv
module dram_row_locator
  import rowloc_pkg::*;
#(
  parameter int N_ROWS     = 8,
  parameter int BND_W      = 8,
  parameter int PAGE_W     = 24,
  parameter int UNIT_SHIFT = 13,
  localparam int IDX_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int ATTR_W = 4 * N_ROWS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_ROWS*BND_W-1:0] bnd_i,
  input  logic [ATTR_W-1:0]       attr_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    q_valid_i,
  input  logic [PAGE_W-1:0]       q_page_i,
  output logic                    r_valid_o,
  output logic                    r_hit_o,
  output logic [IDX_W-1:0]        r_row_o,
  output logic                    r_x4_o,
  output logic [1:0]              r_ecc_o
);

  logic [N_ROWS*PAGE_W-1:0] lo_vec;
  logic [N_ROWS*PAGE_W-1:0] hi_vec;
  logic [N_ROWS-1:0]        pop_vec;
  logic [N_ROWS-1:0]        first_vec;
  logic                     nxt_hit;
  logic [IDX_W-1:0]         nxt_idx;
  logic                     nxt_x4;
  ecc_code_t                nxt_ecc;

  rowloc_bounds #(
    .N_ROWS(N_ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) bounds_i (
    .bnd_i  (bnd_i),
    .gran_i (mode_i[GRAN_BIT]),
    .lo_o   (lo_vec),
    .hi_o   (hi_vec),
    .pop_o  (pop_vec)
  );

  rowloc_match #(
    .N_ROWS(N_ROWS), .PAGE_W(PAGE_W)
  ) match_i (
    .page_i  (q_page_i),
    .lo_i    (lo_vec),
    .hi_i    (hi_vec),
    .pop_i   (pop_vec),
    .first_o (first_vec),
    .hit_o   (nxt_hit),
    .idx_o   (nxt_idx)
  );

  rowloc_attr #(
    .N_ROWS(N_ROWS)
  ) attr_sel_i (
    .attr_i  (attr_i),
    .hit_i   (nxt_hit),
    .idx_i   (nxt_idx),
    .dual_i  (mode_i[CHAN_BIT]),
    .integ_i (mode_i[INTEG_LSB +: 2]),
    .x4_o    (nxt_x4),
    .ecc_o   (nxt_ecc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid_o <= 1'b0;
      r_hit_o   <= 1'b0;
      r_row_o   <= '0;
      r_x4_o    <= 1'b0;
      r_ecc_o   <= 2'd0;
    end else begin
      r_valid_o <= q_valid_i;
      if (q_valid_i) begin
        r_hit_o <= nxt_hit;
        r_row_o <= nxt_idx;
        r_x4_o  <= nxt_x4;
        r_ecc_o <= nxt_ecc;
      end
    end
  end

endmodule

// File: rtl/rowloc_chk.sv
module rowloc_chk #(
  parameter int N_ROWS = 8,
  localparam int IDX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_valid_i,
  input logic [31:0]       mode_i,
  input logic              r_valid_o,
  input logic              r_hit_o,
  input logic [IDX_W-1:0]  r_row_o,
  input logic              r_x4_o,
  input logic [1:0]        r_ecc_o,
  input logic [N_ROWS-1:0] pop_vec,
  input logic [N_ROWS-1:0] first_vec
);

  localparam logic [N_ROWS-1:0] ONE = 1;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid_i |=> r_valid_o);

  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid_i |=> !r_valid_o);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid_i |=> ($stable(r_hit_o) && $stable(r_row_o) && $stable(r_x4_o) && $stable(r_ecc_o)));

  // R5
  hit_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid_o && r_hit_o) |-> (($past(pop_vec) & (ONE << r_row_o)) != '0));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid_o && !r_hit_o) |-> (r_row_o == '0 && !r_x4_o && r_ecc_o == 2'd0));

  // R7
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_vec));

  // R9
  ecc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid_o && $past(mode_i[21:20]) == 2'd0) |-> (r_ecc_o == 2'd0));

  // R9
  ecc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_ecc_o != 2'd3);

endmodule

bind dram_row_locator rowloc_chk #(.N_ROWS(N_ROWS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_valid_i (q_valid_i),
  .mode_i    (mode_i),
  .r_valid_o (r_valid_o),
  .r_hit_o   (r_hit_o),
  .r_row_o   (r_row_o),
  .r_x4_o    (r_x4_o),
  .r_ecc_o   (r_ecc_o),
  .pop_vec   (pop_vec),
  .first_vec (first_vec)
);

// File: tb/dram_row_locator_tb_top.sv
module dram_row_locator_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] bnd_i = '0;
  logic [31:0] attr_i = '0;
  logic [31:0] mode_i = '0;
  logic        q_valid_i = 1'b0;
  logic [23:0] q_page_i = '0;
  logic        r_valid_o, r_hit_o, r_x4_o;
  logic [2:0]  r_row_o;
  logic [1:0]  r_ecc_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_row_locator dut_i (
    .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .attr_i(attr_i), .mode_i(mode_i),
    .q_valid_i(q_valid_i), .q_page_i(q_page_i),
    .r_valid_o(r_valid_o), .r_hit_o(r_hit_o), .r_row_o(r_row_o),
    .r_x4_o(r_x4_o), .r_ecc_o(r_ecc_o)
  );

  // Expected result restated from the requirements
  task automatic model(input logic [23:0] pg, output logic [6:0] exp);
    int unit;
    int lo;
    int hi;
    logic hit;
    int row;
    unit = mode_i[18] ? 16384 : 8192;
    hit = 1'b0;
    row = 0;
    for (int r = 7; r >= 0; r--) begin
      lo = (r == 0) ? 0 : int'(bnd_i[8*(r-1) +: 8]) * unit;
      hi = int'(bnd_i[8*r +: 8]) * unit;
      if (lo != hi && int'(pg) >= lo && int'(pg) < hi) begin
        hit = 1'b1;
        row = r;
      end
    end
    if (!hit) exp = 7'b0;
    else begin
      logic w;
      logic [1:0] e;
      w = attr_i[4*row+3];
      case ({mode_i[21:20] != 2'd0, mode_i[22] & w})
        2'b11:   e = 2'd2;
        2'b10:   e = 2'd1;
        default: e = 2'd0;
      endcase
      exp = {1'b1, 3'(row), w, e};
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/hit/row/x4/ecc=%b expected %b", req, act, exp);
    end
  endtask

  task automatic query(input logic [23:0] pg, input string req);
    logic [6:0] exp;
    @(negedge clk);
    q_valid_i = 1'b1;
    q_page_i  = pg;
    model(pg, exp);
    @(negedge clk);
    q_valid_i = 1'b0;
    check(req, {r_valid_o, r_hit_o, r_row_o, r_x4_o, r_ecc_o}, {1'b1, exp});
  endtask

  function automatic logic [63:0] pack(input int b0, b1, b2, b3, b4, b5, b6, b7);
    return {8'(b7), 8'(b6), 8'(b5), 8'(b4), 8'(b3), 8'(b2), 8'(b1), 8'(b0)};
  endfunction

  task automatic t_reset();
    check("R1", {r_valid_o, r_hit_o, r_row_o, r_x4_o, r_ecc_o}, 8'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {r_valid_o, r_hit_o, r_row_o, r_x4_o, r_ecc_o}, 8'b0);
  endtask

  task automatic t_ranges();
    bnd_i = pack(1, 2, 3, 4, 5, 6, 7, 8);
    mode_i = '0;
    attr_i = '0;
    query(24'd0, "R3 first page");
    query(24'd8191, "R3 last page row0");
    query(24'd8192, "R3 first page row1");
    query(24'd65535, "R3 last page row7");
    query(24'd65536, "R6 above top");
  endtask

  task automatic t_unit();
    mode_i = 32'h0004_0000;  // bit 18 set
    query(24'd8192, "R4 64MiB row0");
    query(24'd16383, "R4 64MiB row0 end");
    query(24'd16384, "R4 64MiB row1");
    query(24'd131071, "R4 64MiB row7");
    query(24'd131072, "R4 64MiB miss");
  endtask

  task automatic t_unpop();
    mode_i = '0;
    bnd_i = pack(2, 2, 5, 5, 5, 8, 8, 8);
    query(24'd16384, "R5 skip empty row1");
    query(24'd49152, "R5 skip empty rows3-4");
    query(24'd16383, "R5 row0 end");
    bnd_i = pack(0, 0, 3, 3, 3, 3, 3, 3);
    query(24'd0, "R5 empty row0");
  endtask

  task automatic t_overlap();
    bnd_i = pack(4, 2, 6, 6, 6, 6, 6, 6);
    query(24'd24576, "R7 overlap lowest wins");
    query(24'd40960, "R7 beyond overlap row2");
  endtask

  task automatic t_attr_ecc();
    bnd_i = pack(1, 2, 3, 4, 5, 6, 7, 8);
    attr_i = 32'h8000_0088;  // rows 0,1,7 are x4
    mode_i = '0;
    query(24'd0, "R8 x4 no integrity");
    mode_i = 32'h0010_0000;  // integrity on, one channel
    query(24'd8192, "R9 single channel x4");
    mode_i = 32'h0050_0000;  // integrity on, two channels
    query(24'd65535, "R9 dual x4 symbol");
    query(24'd16384, "R9 dual x8 secded");
    mode_i = 32'h0060_0000;  // integrity mode 2, two channels
    query(24'd0, "R9 dual x4 mode2");
    query(24'd70000, "R6 miss with ecc on");
  endtask

  task automatic t_hold();
    logic [6:0] exp;
    query(24'd8192, "R2 base");
    model(24'd8192, exp);
    @(negedge clk);
    q_page_i = 24'd0;
    bnd_i = '0;
    @(negedge clk);
    check("R2 hold", {r_valid_o, r_hit_o, r_row_o, r_x4_o, r_ecc_o}, {1'b0, exp});
  endtask

  task automatic t_empty();
    bnd_i = '0;
    query(24'd0, "R6 all zero");
    query(24'd5, "R6 all zero");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_ranges();
    t_unit();
    t_unpop();
    t_overlap();
    t_attr_ecc();
    t_hold();
    t_empty();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end

endmodule